// File: doc/BRIEF.md
# Dual-Source Power Selector and Start-Up Sequencer

This always-on controller decides whether the chip's retained domain is fed from a battery or from a supply harvested from an RF field, and it brings the two internal regulators up in a fixed order. Once a battery is attached, nothing is powered until a rising edge is seen on the external reset pin or a field appears. After that trigger, the controller closes one supply switch, waits for a low-speed tick, and enables the digital regulator. It releases system reset once that regulator and the fast oscillator are stable. It then enables the analog regulator and enters the active mode.

The controller then follows the CPU's sleep requests and the wake events. It moves to the field supply when the battery fails and back when the battery returns. It turns the device fully off when software asks for it and no field is present, and it raises a brown-out interrupt when enabled.

States: `S_OFF` (battery-off), `S_LFO` (waiting for the first low-speed tick), `S_DIG` (digital regulator on, waiting for it and the fast oscillator), `S_ANA` (analog regulator on, waiting for it), `S_ACT` (active), `S_SLP` (sleep), `S_DSL` (deep sleep), `S_DPD` (deep power-down).

Transitions:
- Loss of supply: any state → `S_OFF`.
- Start-up: `S_OFF`→`S_LFO` when power is available. `S_LFO`→`S_DIG` on a tick. `S_DIG`→`S_ANA` when stable. `S_ANA`→`S_ACT` when stable.
- Stage timeout: `S_DIG` or `S_ANA` → `S_OFF`.
- Requests from `S_ACT`: power-off → `S_OFF`, deep power-down → `S_DPD`, deep sleep → `S_DSL`, sleep → `S_SLP`.
- Wake: `S_SLP`→`S_ACT`, `S_DSL`→`S_ANA`, `S_DPD`→`S_DIG`.

Top module: `pwrseq_top`

## Requirements
- R1: After reset, both supply switches stay open and mode stays 0 (battery-off) until `resetn_pin` rises or `fld_ok` goes high. No other input change brings the supply up.
- R2: With both `bat_ok` and `fld_ok` high, the battery switch (`sw_bat`) is the one closed.
- R3: If `bat_ok` falls while `fld_ok` is high, the controller moves to `sw_fld`. It moves back to `sw_bat` when `bat_ok` returns. Every change opens the old switch one cycle before closing the new one, so `sw_bat` and `sw_fld` are never high together.
- R4: While `force_bat` is high, `sw_bat` is closed whatever the comparators say.
- R5: The start-up steps follow one order. First, mode 1 with both regulators off until a `tick`. Next, `ldo_dig_en`, with `sys_rst_n` held low until both `dig_stable` and `fro_stable` are high. Then `ldo_analog` is enabled (`ldo_ana_en`) together with `sys_rst_n`=1. Finally, mode 2 (active) once `ana_stable` is high. `ldo_ana_en` and `sys_rst_n` never assert without `ldo_dig_en`.
- R6: If a start-up stage does not see its stable input within STAGE_TICKS ticks, the controller returns to mode 0 and disarms. With no field present, it then stays off.
- R7: Mode encoding: 0 off, 1 starting, 2 active, 3 sleep, 4 deep sleep, 5 deep power-down. `sleep_req` enters sleep, and any wake event returns to active. When several requests are present, power-off wins over deep power-down, deep power-down over deep sleep, and deep sleep over sleep.
- R8: Deep sleep keeps `ldo_dig_en` and `sys_rst_n` high and turns `ldo_ana_en` off. The following events wake it: `wake_rtc`, `wake_wdt`, `wake_start`, a low `resetn_pin`, a rising `fld_ok`, or `wake_pin` while `wake_pin_en` is high. `wake_pin` has no effect when `wake_pin_en` is low. Wake restarts from the analog stage.
- R9: Deep power-down turns both regulators off and drives `sys_rst_n` low. Only `wake_rtc`, a low `resetn_pin`, a rising `fld_ok`, or an enabled `wake_pin` wake it; `wake_wdt` is ignored. Wake restarts from the digital stage.
- R10: `off_req` in active mode turns the device off and opens both switches, but only while `fld_ok` is low. With a field present, it is ignored.
- R11: When no supply is present (`bat_ok`, `fld_ok` and `force_bat` all low), the controller drops to mode 0 with both regulators off.
- R12: `bod_irq` is high one cycle after `aon_low` and `bod_en` are both high while powered, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| tick | input | 1 | Low-speed oscillator tick, one cycle wide |
| bat_ok | input | 1 | Battery comparator: battery above threshold |
| fld_ok | input | 1 | Field comparator: harvested supply present |
| force_bat | input | 1 | Override: always select the battery |
| resetn_pin | input | 1 | External reset pin level |
| dig_stable | input | 1 | Digital regulator output stable |
| fro_stable | input | 1 | Fast oscillator stable |
| ana_stable | input | 1 | Analog regulator output stable |
| sleep_req | input | 1 | CPU sleep entry request |
| dsleep_req | input | 1 | CPU deep-sleep entry request |
| dpd_req | input | 1 | Deep power-down request |
| off_req | input | 1 | Software power-off request |
| wake_rtc | input | 1 | Real-time counter expiry |
| wake_pin | input | 1 | Wake pin event |
| wake_pin_en | input | 1 | Enable for the wake pin |
| wake_wdt | input | 1 | Watchdog event |
| wake_start | input | 1 | Enabled start-logic interrupt |
| bod_en | input | 1 | Brown-out detection enable |
| aon_low | input | 1 | Always-on supply below brown-out level |
| sw_bat | output | 1 | Close battery supply switch |
| sw_fld | output | 1 | Close field supply switch |
| ldo_dig_en | output | 1 | Digital regulator enable |
| ldo_ana_en | output | 1 | Analog regulator enable |
| sys_rst_n | output | 1 | System reset, active low |
| mode | output | 3 | Power mode code (see R7) |
| bod_irq | output | 1 | Brown-out interrupt |

## Verification
The bench builds the block with STAGE_TICKS set to 3. With that value, a stage timeout needs only a few tick pulses, so the bench can stop one tick short of the limit and then cross it. Because `tick` is a free input held low, the bench can park the sequencer in its first stage and step each stage by hand. This lets it observe every regulator and reset output between steps.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
    typedef enum logic [1:0] {SRC_NONE, SRC_BAT, SRC_FLD} src_e;
    typedef enum logic [2:0] {S_OFF, S_LFO, S_DIG, S_ANA, S_ACT, S_SLP, S_DSL, S_DPD} seq_e;
    localparam logic [2:0] MODE_OFF   = 3'd0;
    localparam logic [2:0] MODE_START = 3'd1;
    localparam logic [2:0] MODE_ACT   = 3'd2;
    localparam logic [2:0] MODE_SLP   = 3'd3;
    localparam logic [2:0] MODE_DSL   = 3'd4;
    localparam logic [2:0] MODE_DPD   = 3'd5;
endpackage

// File: rtl/pwrseq_src_sel.sv
module pwrseq_src_sel
    import pwrseq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bat_ok,
    input  logic fld_ok,
    input  logic force_bat,
    input  logic resetn_pin,
    input  logic disarm,
    output logic pwr_ok,
    output logic sw_bat,
    output logic sw_fld
);
    logic pin_q;
    logic armed_q;
    src_e cur_q, cur_d, tgt;
    logic present, pin_rise;

    always_comb begin
        present  = force_bat | bat_ok | fld_ok;
        pin_rise = resetn_pin & ~pin_q;
        if (!armed_q)                tgt = SRC_NONE;
        else if (force_bat || bat_ok) tgt = SRC_BAT;
        else if (fld_ok)             tgt = SRC_FLD;
        else                         tgt = SRC_NONE;
        // open the old switch for one cycle before closing the new one
        if (cur_q != SRC_NONE && tgt != cur_q) cur_d = SRC_NONE;
        else                                  cur_d = tgt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_q   <= 1'b1;
            armed_q <= 1'b0;
            cur_q   <= SRC_NONE;
        end else begin
            pin_q <= resetn_pin;
            cur_q <= cur_d;
            if (pin_rise || fld_ok)     armed_q <= 1'b1;
            else if (disarm || !present) armed_q <= 1'b0;
        end
    end

    assign pwr_ok = armed_q & present;
    assign sw_bat = (cur_q == SRC_BAT);
    assign sw_fld = (cur_q == SRC_FLD);

    AST_NO_BOTH_SWITCHES: assert property (@(posedge clk) disable iff (!rst_n)
        !(sw_bat && sw_fld)); // R3
    AST_BAT_KEEPS_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && bat_ok && sw_bat) |=> sw_bat); // R2
    AST_STAY_OFF_UNTRIGGERED: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed_q && !pin_rise && !fld_ok) |=> !armed_q); // R1
endmodule

// File: rtl/pwrseq_stage_timer.sv
module pwrseq_stage_timer #(
    parameter int LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   cnt_q <= '0;
        else if (clr)                 cnt_q <= '0;
        else if (tick && cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
    end

    assign expired = (cnt_q == LIM);

    AST_TMR_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIM); // R6
endmodule

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm
    import pwrseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_ok,
    input  logic       tick,
    input  logic       fld_ok,
    input  logic       resetn_pin,
    input  logic       dig_stable,
    input  logic       fro_stable,
    input  logic       ana_stable,
    input  logic       sleep_req,
    input  logic       dsleep_req,
    input  logic       dpd_req,
    input  logic       off_req,
    input  logic       wake_rtc,
    input  logic       wake_pin,
    input  logic       wake_pin_en,
    input  logic       wake_wdt,
    input  logic       wake_start,
    input  logic       tmr_exp,
    output logic       tmr_clr,
    output logic       disarm,
    output logic       ldo_dig_en,
    output logic       ldo_ana_en,
    output logic       sys_rst_n,
    output logic [2:0] mode
);
    seq_e state_q, state_d;
    logic fld_q;
    logic fld_rise, pin_wake, wake_dpd, wake_dsl, off_go;

    always_comb begin
        fld_rise = fld_ok & ~fld_q;
        pin_wake = wake_pin & wake_pin_en;
        wake_dpd = wake_rtc | pin_wake | fld_rise | ~resetn_pin;
        wake_dsl = wake_dpd | wake_wdt | wake_start;
        off_go   = off_req & ~fld_ok;
    end

    always_comb begin
        state_d = state_q;
        disarm  = 1'b0;
        if (!pwr_ok) begin
            state_d = S_OFF;
        end else begin
            unique case (state_q)
                S_OFF: state_d = S_LFO;
                S_LFO: if (tick) state_d = S_DIG;
                S_DIG: begin
                    if (dig_stable && fro_stable) state_d = S_ANA;
                    else if (tmr_exp) begin
                        state_d = S_OFF;
                        disarm  = 1'b1;
                    end
                end
                S_ANA: begin
                    if (ana_stable) state_d = S_ACT;
                    else if (tmr_exp) begin
                        state_d = S_OFF;
                        disarm  = 1'b1;
                    end
                end
                S_ACT: begin
                    if (off_go) begin
                        state_d = S_OFF;
                        disarm  = 1'b1;
                    end
                    else if (dpd_req)    state_d = S_DPD;
                    else if (dsleep_req) state_d = S_DSL;
                    else if (sleep_req)  state_d = S_SLP;
                end
                S_SLP: if (wake_dsl) state_d = S_ACT;
                S_DSL: if (wake_dsl) state_d = S_ANA;
                S_DPD: if (wake_dpd) state_d = S_DIG;
                default: state_d = S_OFF;
            endcase
        end
        tmr_clr = (state_d != state_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_OFF;
            fld_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            fld_q   <= fld_ok;
        end
    end

    always_comb begin
        ldo_dig_en = 1'b0;
        ldo_ana_en = 1'b0;
        sys_rst_n  = 1'b0;
        mode       = MODE_OFF;
        unique case (state_q)
            S_OFF: mode = MODE_OFF;
            S_LFO: mode = MODE_START;
            S_DIG: begin
                mode       = MODE_START;
                ldo_dig_en = 1'b1;
            end
            S_ANA: begin
                mode       = MODE_START;
                ldo_dig_en = 1'b1;
                ldo_ana_en = 1'b1;
                sys_rst_n  = 1'b1;
            end
            S_ACT, S_SLP: begin
                mode       = (state_q == S_ACT) ? MODE_ACT : MODE_SLP;
                ldo_dig_en = 1'b1;
                ldo_ana_en = 1'b1;
                sys_rst_n  = 1'b1;
            end
            S_DSL: begin
                mode       = MODE_DSL;
                ldo_dig_en = 1'b1;
                sys_rst_n  = 1'b1;
            end
            S_DPD: mode = MODE_DPD;
            default: mode = MODE_OFF;
        endcase
    end

    AST_ANA_NEEDS_DIG: assert property (@(posedge clk) disable iff (!rst_n)
        ldo_ana_en |-> ldo_dig_en); // R5
    AST_RST_NEEDS_DIG: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_n |-> ldo_dig_en); // R5
    AST_LOSS_GOES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok |=> (mode == MODE_OFF)); // R11
    AST_DPD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DPD && pwr_ok && !wake_dpd) |=> (mode == MODE_DPD)); // R9
endmodule

// File: rtl/pwrseq_top.sv
module pwrseq_top #(
    parameter int STAGE_TICKS = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       bat_ok,
    input  logic       fld_ok,
    input  logic       force_bat,
    input  logic       resetn_pin,
    input  logic       dig_stable,
    input  logic       fro_stable,
    input  logic       ana_stable,
    input  logic       sleep_req,
    input  logic       dsleep_req,
    input  logic       dpd_req,
    input  logic       off_req,
    input  logic       wake_rtc,
    input  logic       wake_pin,
    input  logic       wake_pin_en,
    input  logic       wake_wdt,
    input  logic       wake_start,
    input  logic       bod_en,
    input  logic       aon_low,
    output logic       sw_bat,
    output logic       sw_fld,
    output logic       ldo_dig_en,
    output logic       ldo_ana_en,
    output logic       sys_rst_n,
    output logic [2:0] mode,
    output logic       bod_irq
);
    logic pwr_ok, disarm, tmr_clr, tmr_exp;

    pwrseq_src_sel u_src (
        .clk(clk), .rst_n(rst_n), .bat_ok(bat_ok), .fld_ok(fld_ok),
        .force_bat(force_bat), .resetn_pin(resetn_pin), .disarm(disarm),
        .pwr_ok(pwr_ok), .sw_bat(sw_bat), .sw_fld(sw_fld)
    );

    pwrseq_stage_timer #(.LIMIT(STAGE_TICKS)) u_tmr (
        .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .tick(tick), .expired(tmr_exp)
    );

    pwrseq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .tick(tick), .fld_ok(fld_ok),
        .resetn_pin(resetn_pin), .dig_stable(dig_stable), .fro_stable(fro_stable),
        .ana_stable(ana_stable), .sleep_req(sleep_req), .dsleep_req(dsleep_req),
        .dpd_req(dpd_req), .off_req(off_req), .wake_rtc(wake_rtc), .wake_pin(wake_pin),
        .wake_pin_en(wake_pin_en), .wake_wdt(wake_wdt), .wake_start(wake_start),
        .tmr_exp(tmr_exp), .tmr_clr(tmr_clr), .disarm(disarm),
        .ldo_dig_en(ldo_dig_en), .ldo_ana_en(ldo_ana_en), .sys_rst_n(sys_rst_n),
        .mode(mode)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bod_irq <= 1'b0;
        else        bod_irq <= pwr_ok & bod_en & aon_low;
    end
endmodule

// File: tb/pwrseq_top_tb_top.sv
module pwrseq_top_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 0, bat_ok = 0, fld_ok = 0, force_bat = 0, resetn_pin = 1;
    logic dig_stable = 0, fro_stable = 0, ana_stable = 0;
    logic sleep_req = 0, dsleep_req = 0, dpd_req = 0, off_req = 0;
    logic wake_rtc = 0, wake_pin = 0, wake_pin_en = 0, wake_wdt = 0, wake_start = 0;
    logic bod_en = 0, aon_low = 0;
    logic sw_bat, sw_fld, ldo_dig_en, ldo_ana_en, sys_rst_n, bod_irq;
    logic [2:0] mode;
    int n_run = 0, n_fail = 0, both_cnt = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pwrseq_top #(.STAGE_TICKS(3)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bat_ok(bat_ok), .fld_ok(fld_ok),
        .force_bat(force_bat), .resetn_pin(resetn_pin), .dig_stable(dig_stable),
        .fro_stable(fro_stable), .ana_stable(ana_stable), .sleep_req(sleep_req),
        .dsleep_req(dsleep_req), .dpd_req(dpd_req), .off_req(off_req),
        .wake_rtc(wake_rtc), .wake_pin(wake_pin), .wake_pin_en(wake_pin_en),
        .wake_wdt(wake_wdt), .wake_start(wake_start), .bod_en(bod_en),
        .aon_low(aon_low), .sw_bat(sw_bat), .sw_fld(sw_fld),
        .ldo_dig_en(ldo_dig_en), .ldo_ana_en(ldo_ana_en), .sys_rst_n(sys_rst_n),
        .mode(mode), .bod_irq(bod_irq)
    );

    // {bat_ok, fld_ok, force_bat, expected sw_bat, expected sw_fld}
    localparam logic [4:0] VEC [7] = '{
        5'b110_10, 5'b010_01, 5'b100_10, 5'b001_10,
        5'b011_10, 5'b111_10, 5'b010_01
    };

    always @(negedge clk) if (rst_n && sw_bat && sw_fld) both_cnt++;

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %0h exp %0h", req, got, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pin_pulse();
        resetn_pin = 0; cyc(2); resetn_pin = 1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        bat_ok = 1;
        cyc(3); rst_n = 1; cyc(6);
        // R1: battery attached but no trigger yet
        chk("R1 sw_bat off before trigger", {7'd0, sw_bat}, 8'd0);
        chk("R1 mode off before trigger", {5'd0, mode}, 8'd0);
        chk("R1 sys_rst_n low", {7'd0, sys_rst_n}, 8'd0);
        pin_pulse(); cyc(4);
        chk("R1 sw_bat after pin rise", {7'd0, sw_bat}, 8'd1);
        chk("R5 mode starting", {5'd0, mode}, 8'd1);
        chk("R5 no dig ldo before tick", {7'd0, ldo_dig_en}, 8'd0);
        tick = 1; cyc(1); tick = 0; cyc(2);
        chk("R5 dig ldo after tick", {7'd0, ldo_dig_en}, 8'd1);
        chk("R5 ana ldo still off", {7'd0, ldo_ana_en}, 8'd0);
        dig_stable = 1; cyc(3);
        chk("R5 reset held without fro", {7'd0, sys_rst_n}, 8'd0);
        fro_stable = 1; cyc(2);
        chk("R5 reset released", {7'd0, sys_rst_n}, 8'd1);
        chk("R5 ana ldo on", {7'd0, ldo_ana_en}, 8'd1);
        chk("R5 still starting", {5'd0, mode}, 8'd1);
        ana_stable = 1; cyc(3);
        chk("R5 active", {5'd0, mode}, 8'd2);

        // R2 R3 R4: source selection table
        for (int i = 0; i < 7; i++) begin
            {bat_ok, fld_ok, force_bat} = VEC[i][4:2];
            cyc(4);
            chk("R2/R3/R4 switches", {6'd0, sw_bat, sw_fld}, {6'd0, VEC[i][1:0]});
            chk("R3 stays active", {5'd0, mode}, 8'd2);
        end
        bat_ok = 1; fld_ok = 0; force_bat = 0; cyc(4);

        // R7 sleep and priority
        sleep_req = 1; cyc(1); sleep_req = 0; cyc(2);
        chk("R7 sleep", {5'd0, mode}, 8'd3);
        wake_start = 1; cyc(1); wake_start = 0; cyc(2);
        chk("R7 wake from sleep", {5'd0, mode}, 8'd2);
        dpd_req = 1; sleep_req = 1; cyc(1); dpd_req = 0; sleep_req = 0; cyc(2);
        chk("R7 dpd over sleep", {5'd0, mode}, 8'd5);
        wake_rtc = 1; cyc(1); wake_rtc = 0; cyc(4);
        chk("R9 rtc wake", {5'd0, mode}, 8'd2);

        // R8 deep sleep
        dsleep_req = 1; cyc(1); dsleep_req = 0; cyc(2);
        chk("R8 deep sleep mode", {5'd0, mode}, 8'd4);
        chk("R8 regulators", {5'd0, ldo_dig_en, ldo_ana_en, sys_rst_n}, 8'b101);
        wake_pin = 1; cyc(1); wake_pin = 0; cyc(3);
        chk("R8 disabled pin ignored", {5'd0, mode}, 8'd4);
        wake_wdt = 1; cyc(1); wake_wdt = 0; cyc(4);
        chk("R8 wdt wake", {5'd0, mode}, 8'd2);

        // R9 deep power-down
        dpd_req = 1; cyc(1); dpd_req = 0; cyc(2);
        chk("R9 dpd mode", {5'd0, mode}, 8'd5);
        chk("R9 all off", {5'd0, ldo_dig_en, ldo_ana_en, sys_rst_n}, 8'b000);
        wake_wdt = 1; cyc(1); wake_wdt = 0; cyc(3);
        chk("R9 wdt ignored", {5'd0, mode}, 8'd5);
        wake_pin_en = 1; wake_pin = 1; cyc(1); wake_pin = 0; cyc(4);
        chk("R9 enabled pin wake", {5'd0, mode}, 8'd2);
        wake_pin_en = 0;
        dpd_req = 1; cyc(1); dpd_req = 0; cyc(3);
        fld_ok = 1; cyc(5);
        chk("R9 field wake", {5'd0, mode}, 8'd2);
        chk("R2 battery kept with field", {6'd0, sw_bat, sw_fld}, 8'b10);

        // R10 power-off request
        off_req = 1; cyc(1); off_req = 0; cyc(3);
        chk("R10 off ignored with field", {5'd0, mode}, 8'd2);
        fld_ok = 0; cyc(2);
        off_req = 1; cyc(1); off_req = 0; cyc(4);
        chk("R10 off mode", {5'd0, mode}, 8'd0);
        chk("R10 switches open", {6'd0, sw_bat, sw_fld}, 8'b00);
        cyc(6);
        chk("R10 stays off", {5'd0, mode}, 8'd0);

        // R6 stage timeout
        dig_stable = 0;
        pin_pulse(); cyc(4);
        tick = 1; cyc(1); tick = 0; cyc(2);
        for (int k = 0; k < 2; k++) begin
            tick = 1; cyc(1); tick = 0; cyc(1);
        end
        cyc(2);
        chk("R6 waiting below limit", {6'd0, mode[1:0], ldo_dig_en}, 8'b011);
        tick = 1; cyc(1); tick = 0; cyc(4);
        chk("R6 timeout off", {5'd0, mode}, 8'd0);
        chk("R6 disarmed", {7'd0, sw_bat}, 8'd0);

        // R1 R3 field-only start, R11 loss
        dig_stable = 1; bat_ok = 0; fld_ok = 1; cyc(4);
        chk("R1 field starts up", {6'd0, sw_bat, sw_fld}, 8'b01);
        tick = 1; cyc(1); tick = 0; cyc(4);
        chk("R5 active on field", {5'd0, mode}, 8'd2);
        fld_ok = 0; cyc(3);
        chk("R11 supply lost", {5'd0, mode}, 8'd0);
        chk("R11 ldo off", {7'd0, ldo_dig_en}, 8'd0);

        // R12 brown-out
        bod_en = 1; aon_low = 1; cyc(3);
        chk("R12 no irq unpowered", {7'd0, bod_irq}, 8'd0);
        bat_ok = 1; pin_pulse(); cyc(3);
        chk("R12 irq raised", {7'd0, bod_irq}, 8'd1);
        bod_en = 0; cyc(2);
        chk("R12 irq disabled", {7'd0, bod_irq}, 8'd0);

        chk("R3 never both closed", both_cnt[7:0], 8'd0);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule